// File: doc/BRIEF.md
# Round-Robin Arbiter With Usage-Confirmed Rotation

This block shares one resource among a parameterised number of requesters. Each requester raises its own bit of a request vector. In the same cycle the arbiter returns a one-hot grant that names exactly one of the active requesters. When no requester is active, the grant is all zeros.

Priority follows a circular order that starts from a registered "top" position. The top position does not advance just because a grant was issued. It moves only when the unit that holds the grant raises the usage strobe to confirm that it actually used the resource. The requester just after the served one then becomes the new top, so the served unit falls to the lowest priority until every other active requester has had a turn. Without a confirmation, the same winner keeps the grant for as long as it requests.

Top module: `rr_grant_arbiter`

## Requirements
- R1: The grant vector has at most one bit set, and that bit is always a bit that is set in the request vector.
- R2: If no request bit is set, the grant is all zeros. If any request bit is set, exactly one grant bit is set.
- R3: After reset, requester 0 has the highest priority, and priority falls with ascending index. With all requests active, the grant is bit 0 (0001 for four requesters).
- R4: While the usage strobe is low and the request vector is unchanged, the grant stays the same from cycle to cycle.
- R5: A usage strobe in a cycle where requester i is granted makes requester i+1 the highest priority from the next cycle on. A different active requester then wins ahead of i.
- R6: A confirmed use by the last requester (index N_REQ-1) wraps the top priority back to requester 0.
- R7: A usage strobe in a cycle with no request active leaves the priority order unchanged.
- R8: The grant is combinational. A change of the request vector shows on the grant in the same cycle, with no register stage in between.
- R9: Driving the active-low synchronous reset low at any time brings the priority back to its initial state, the same as in R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N_REQ | Request vector, one bit per requester |
| used | input | 1 | Strobe: the current grant holder consumed the resource |
| grant | output | N_REQ | One-hot grant, all zeros when idle |

## Verification
The bound checker looks at every cycle. It checks that the grant is one-hot or zero and always within the request vector, and that the grant is zero exactly when nothing requests. It also checks that the grant holds steady while neither the requests nor the strobe change, and that a served requester loses to any competitor in the next cycle. The exact order of rotation needs the bench's directed scenarios, because only a known sequence of requests and strobes shows it. These scenarios cover the wrap from the last requester to requester 0, the strobe having no effect when idle, and the return to requester 0 after a mid-run reset.

// File: rtl/rrarb_pkg.sv
// Package rrarb_pkg
// Helpers shared by the arbiter modules.
// Assumes: indices lie in the range 0 .. n-1.
package rrarb_pkg;

    // Returns the circular successor of index i within a ring of n entries.
    function automatic int ring_next(input int i, input int n);
        return (i + 1 >= n) ? 0 : i + 1;
    endfunction

    // Returns (base + offset) folded back into the range 0 .. n-1.
    function automatic int ring_add(input int base, input int offset, input int n);
        return (base + offset) % n;
    endfunction

endpackage

// File: rtl/rr_pick.sv
// Module rr_pick
// Combinational selector. Starting at position 'top' and walking the ring
// upward, it grants the first request it finds.
// Assumes: top < N_REQ. The output is one-hot, or zero when req is zero.
module rr_pick #(
    parameter int N_REQ = 4,
    localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0] req,
    input  logic [IW-1:0]    top,
    output logic [N_REQ-1:0] grant
);
    import rrarb_pkg::*;

    // Scan the ring from top and keep only the first active request.
    always_comb begin
        logic          found;
        logic [IW-1:0] pos;
        grant = '0;
        found = 1'b0;
        for (int k = 0; k < N_REQ; k++) begin
            pos = IW'(ring_add(int'(top), k, N_REQ));
            if (!found && req[pos]) begin
                grant[pos] = 1'b1;
                found      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rr_oh_encode.sv
// Module rr_oh_encode
// Converts a one-hot vector into its binary index.
// Assumes: at most one bit of oh is set. A zero input gives index 0.
module rr_oh_encode #(
    parameter int N_REQ = 4,
    localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic [N_REQ-1:0] oh,
    output logic [IW-1:0]    idx
);
    // OR together the index of each set bit.
    always_comb begin
        idx = '0;
        for (int j = 0; j < N_REQ; j++) begin
            if (oh[j]) idx = idx | IW'(j);
        end
    end

endmodule

// File: rtl/rr_top_ptr.sv
// Module rr_top_ptr
// Holds the highest-priority position. It moves to the successor of the
// winner only when the usage strobe arrives while a grant is active.
// Assumes: win is valid whenever any_grant is high.
module rr_top_ptr #(
    parameter int N_REQ = 4,
    localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          used,
    input  logic          any_grant,
    input  logic [IW-1:0] win,
    output logic [IW-1:0] top
);
    import rrarb_pkg::*;

    logic [IW-1:0] top_nxt;

    // Successor of the winner, wrapping to 0 after the last requester.
    always_comb top_nxt = IW'(ring_next(int'(win), N_REQ));

    // Reset to requester 0. Advance only on a confirmed use.
    always_ff @(posedge clk) begin
        if (!rst_n)                top <= '0;
        else if (used && any_grant) top <= top_nxt;
    end

endmodule

// File: rtl/rr_grant_arbiter.sv
// Module rr_grant_arbiter
// Round-robin arbiter whose priority moves only when use is confirmed.
// The grant is combinational from req and the registered top position.
// Assumes: used is meaningful only in a cycle where a grant is active.
module rr_grant_arbiter #(
    parameter int N_REQ = 4,
    localparam int IW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req,
    input  logic             used,
    output logic [N_REQ-1:0] grant
);
    logic [IW-1:0] top;
    logic [IW-1:0] win;
    logic          any_grant;

    // Pick the winner for this cycle.
    rr_pick #(.N_REQ(N_REQ)) u_pick (
        .req   (req),
        .top   (top),
        .grant (grant)
    );

    // Turn the winner back into an index for the pointer update.
    rr_oh_encode #(.N_REQ(N_REQ)) u_enc (
        .oh  (grant),
        .idx (win)
    );

    // A grant is active whenever any grant bit is set.
    always_comb any_grant = |grant;

    // Priority pointer register.
    rr_top_ptr #(.N_REQ(N_REQ)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .used      (used),
        .any_grant (any_grant),
        .win       (win),
        .top       (top)
    );

endmodule

// File: rtl/rr_grant_arbiter_chk.sv
// Module rr_grant_arbiter_chk
// Property checker attached to every rr_grant_arbiter instance.
// Assumes: observes the arbiter's ports only.
module rr_grant_arbiter_chk #(
    parameter int N_REQ = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_REQ-1:0] req,
    input logic             used,
    input logic [N_REQ-1:0] grant
);
    // R1: the grant is one-hot or zero.
    p_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R1: only a requester can be granted.
    p_subset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0);

    // R2: nothing requested gives no grant.
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0) |-> (grant == '0));

    // R2: any request gives exactly one grant.
    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req != '0) |-> ($countones(grant) == 1));

    // R4: no strobe and unchanged requests keep the grant.
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !used |=> (req != $past(req)) || (grant == $past(grant)));

    // R5: a served unit loses to any competitor in the next cycle.
    p_demote_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (used && grant != '0) |=> ($countones(req) < 2) || (grant != $past(grant)));

endmodule

bind rr_grant_arbiter rr_grant_arbiter_chk #(.N_REQ(N_REQ)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req),
    .used  (used),
    .grant (grant)
);

// File: tb/rr_grant_arbiter_test.sv
// Directed bench for rr_grant_arbiter with four requesters.
module rr_grant_arbiter_test;
    localparam int CLK_NS = 10;
    localparam int N      = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         used = 1'b0;
    logic [N-1:0] grant;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    rr_grant_arbiter #(.N_REQ(N)) uut (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .used  (used),
        .grant (grant)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Record one comparison of the grant against its expected value.
    task automatic chk(input string tag, input logic [N-1:0] exp);
        total++;
        if (grant !== exp) begin
            bad++;
            $display("FAIL %s grant=%b expected=%b", tag, grant, exp);
        end
    endtask

    // Drive the inputs just after a falling edge and let them settle.
    task automatic drive(input logic [N-1:0] r, input logic u);
        @(negedge clk);
        req  = r;
        used = u;
        #1;
    endtask

    // Hold reset for two cycles, then release it.
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; used = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R3: the reset state gives priority to requester 0.
    task automatic t_reset_state();
        do_reset();
        drive(4'b0000, 1'b0); chk("R2 idle after reset", 4'b0000);
        drive(4'b1111, 1'b0); chk("R3 all request", 4'b0001);
        drive(4'b1100, 1'b0); chk("R3 lowest index wins", 4'b0100);
    endtask

    // R4 and R8: without a strobe the winner holds; the grant follows req at once.
    task automatic t_hold();
        do_reset();
        for (int k = 0; k < 3; k++) begin
            drive(4'b0110, 1'b0); chk("R4 hold without strobe", 4'b0010);
        end
        @(negedge clk);
        req = 4'b0100; #1;
        chk("R8 same-cycle response", 4'b0100);
        req = 4'b0000; #1;
        chk("R8 drop to idle", 4'b0000);
    endtask

    // R5 and R6: a confirmed use rotates the priority and wraps at the end.
    task automatic t_rotate();
        do_reset();
        drive(4'b1111, 1'b1); chk("R5 rotate step 0", 4'b0001);
        drive(4'b1111, 1'b1); chk("R5 rotate step 1", 4'b0010);
        drive(4'b1111, 1'b1); chk("R5 rotate step 2", 4'b0100);
        drive(4'b1111, 1'b1); chk("R5 rotate step 3", 4'b1000);
        drive(4'b1111, 1'b0); chk("R6 wrap to requester 0", 4'b0001);
    endtask

    // R5 and R6 with sparse requests.
    task automatic t_sparse();
        do_reset();
        drive(4'b1010, 1'b1); chk("R5 sparse first", 4'b0010);
        drive(4'b1010, 1'b1); chk("R5 sparse demoted", 4'b1000);
        drive(4'b1010, 1'b0); chk("R6 sparse wrap", 4'b0010);
        drive(4'b0011, 1'b0); chk("R6 top back at zero", 4'b0001);
    endtask

    // R7: a strobe with no request leaves the priority alone.
    task automatic t_idle_strobe();
        do_reset();
        drive(4'b0100, 1'b1); chk("R7 setup grant", 4'b0100);
        drive(4'b0000, 1'b1); chk("R7 idle strobe", 4'b0000);
        drive(4'b0000, 1'b1); chk("R7 idle strobe again", 4'b0000);
        drive(4'b1111, 1'b0); chk("R7 top still 3", 4'b1000);
    endtask

    // R9: reset in mid-run restores the initial priority.
    task automatic t_mid_reset();
        drive(4'b1111, 1'b1); chk("R9 pre-reset", 4'b1000);
        drive(4'b1111, 1'b0); chk("R9 moved to 0", 4'b0001);
        drive(4'b1111, 1'b1); chk("R9 moved again", 4'b0001);
        drive(4'b1111, 1'b0); chk("R9 top at 1", 4'b0010);
        do_reset();
        drive(4'b1111, 1'b0); chk("R9 back to requester 0", 4'b0001);
    endtask

    initial begin
        t_reset_state();
        t_hold();
        t_rotate();
        t_sparse();
        t_idle_strobe();
        t_mid_reset();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog grant=%b expected=finish", grant);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule